// File: doc/BRIEF.md
# Half-rate DDR write command sequencer

This block is the write path of a custom controller that drives a DDR or DDR2 PHY at half rate. Every controller clock carries two memory clock slots. Each two-bit control lane is packed with bit 0 sent on the first memory clock and bit 1 on the second. One accepted write request produces three things: a one-cycle command and address phase, then a strobe preamble, then two controller cycles of burst-of-eight data with per-byte masks.

The write latency, counted in controller cycles from the command cycle to the first data cycle, is fixed by calibration. It is captured when calibration signals completion and is held after that. A mode input chooses how partial writes behave. In one mode the strobes and data-valid lanes are driven exactly as for a full write, and only the masks mark the bytes that are skipped. In the other mode, a power-saving mode, the data-valid bit of any memory clock slot whose bytes are all masked is dropped.

Top module: `hr_write_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `cs_n` is 2'b11, `dqs_burst`, `wdata_valid`, `wdata`, `dm` and `addr` are all zero, and `ready` stays low until the first `cal_done` pulse.
- R2: A `wr_req` that arrives before any `cal_done` pulse is refused and produces no command.
- R3: A request accepted while `ready` is high gives exactly one command cycle on the next clock. In that cycle `cs_n` is 2'b01 (bit 0 sent first) and `addr` is {`wr_addr`, `wr_addr`}.
- R4: With latency L counted from the command cycle, `dqs_burst` is 2'b10 (preamble, bit 0 first) in cycle L-1, 2'b11 in cycles L and L+1, and 2'b00 at all other times. A captured latency of 0 is treated as 1.
- R5: In data cycle L, `wdata` carries beats 0..3 of `wr_data`, and in cycle L+1 it carries beats 4..7. Beat b occupies `wr_data[b*DQ_W +: DQ_W]`, and within each data cycle the earliest beat is in the low bits. `dm` is the inverse of the matching `wr_be` bits, using the same beat-major, byte-minor layout with BYTES bits per beat. Outside the data cycles, `wdata` and `dm` are zero.
- R6: With `save_mode` at 0, `wdata_valid` is 2'b11 in both data cycles, whatever the byte enables are.
- R7: With `save_mode` at 1, `wdata_valid` bit j in a data cycle is 0 exactly when every byte of that cycle's beats 2j and 2j+1 is disabled. The strobes are unchanged.
- R8: `ready` is low from the command cycle through the last data cycle and high on the cycle after that. Requests made while `ready` is low are ignored.
- R9: `lat_in` is sampled only on a `cal_done` pulse while the block is idle. Later changes to `lat_in` without a pulse do not change the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_done | input | 1 | Calibration-complete pulse; captures `lat_in` |
| lat_in | input | LAT_W | Calibrated write latency in controller cycles |
| save_mode | input | 1 | 1: drop data-valid for fully masked slots |
| wr_req | input | 1 | Write request |
| wr_addr | input | ADDR_W | Memory address of the write |
| wr_data | input | 8*DQ_W | Eight beats of write data, beat 0 lowest |
| wr_be | input | 8*DQ_W/8 | Byte enables, beat-major |
| ready | output | 1 | Block can accept a request |
| cs_n | output | 2 | Chip select per memory clock slot, bit 0 first |
| addr | output | 2*ADDR_W | Address, duplicated over both slots |
| dqs_burst | output | 2 | Strobe enable per slot |
| wdata_valid | output | 2 | Data-valid per slot |
| wdata | output | 4*DQ_W | Four beats of data per controller cycle |
| dm | output | 4*DQ_W/8 | Data masks, 1 = byte not written |

## Verification
The hardest case to reach is the power-saving slot drop. It needs a request whose byte enables clear one whole memory clock slot while the other slots stay live, and it has to be issued with the mode pin set. The bench drives that pattern in both modes and compares the valid lanes slot by slot. It also covers the one-cycle latency, where the preamble lands in the command cycle itself. It reaches that case by recalibrating with a latency of zero. A request is also made in the middle of a burst, and a latency change is made without a calibration pulse, to show that neither one has any effect.

// File: rtl/hr_write_seq.sv
module hr_write_seq #(
  parameter int ADDR_W = 13,
  parameter int DQ_W   = 16,
  parameter int LAT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cal_done,
  input  logic [LAT_W-1:0]      lat_in,
  input  logic                  save_mode,
  input  logic                  wr_req,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [8*DQ_W-1:0]     wr_data,
  input  logic [8*DQ_W/8-1:0]   wr_be,
  output logic                  ready,
  output logic [1:0]            cs_n,
  output logic [2*ADDR_W-1:0]   addr,
  output logic [1:0]            dqs_burst,
  output logic [1:0]            wdata_valid,
  output logic [4*DQ_W-1:0]     wdata,
  output logic [4*DQ_W/8-1:0]   dm
);
  localparam int BYTES = DQ_W / 8;
  localparam int HALF  = 4 * BYTES;
  localparam int SLOT  = 2 * BYTES;

  logic              cal_ok, busy;
  logic [LAT_W-1:0]  lat_q;
  logic [LAT_W:0]    ph, lat_x, lat_m1, lat_p1;
  logic [ADDR_W-1:0] addr_q;
  logic [8*DQ_W-1:0] data_q;
  logic [8*BYTES-1:0] be_q;

  assign lat_x  = {1'b0, lat_q};
  assign lat_m1 = lat_x - 1'b1;
  assign lat_p1 = lat_x + 1'b1;
  assign ready  = cal_ok && !busy;

  wire accept = wr_req && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_ok <= 1'b0;
      lat_q  <= LAT_W'(1);
      busy   <= 1'b0;
      ph     <= '0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else begin
      if (cal_done && !busy) begin
        cal_ok <= 1'b1;
        lat_q  <= (lat_in == '0) ? LAT_W'(1) : lat_in;
      end
      if (accept) begin
        busy   <= 1'b1;
        ph     <= '0;
        addr_q <= wr_addr;
        data_q <= wr_data;
        be_q   <= wr_be;
      end else if (busy) begin
        ph <= ph + 1'b1;
        if (ph == lat_p1) busy <= 1'b0;
      end
    end
  end

  wire is_cmd  = busy && (ph == '0);
  wire is_pre  = busy && (ph == lat_m1);
  wire is_d0   = busy && (ph == lat_x);
  wire is_d1   = busy && (ph == lat_p1);
  wire in_data = is_d0 || is_d1;

  wire [4*DQ_W-1:0] data_cur = is_d1 ? data_q[4*DQ_W +: 4*DQ_W] : data_q[0 +: 4*DQ_W];
  wire [HALF-1:0]   be_cur   = is_d1 ? be_q[HALF +: HALF] : be_q[0 +: HALF];
  wire [1:0]        slot_live = {|be_cur[SLOT +: SLOT], |be_cur[0 +: SLOT]};

  assign cs_n        = is_cmd ? 2'b01 : 2'b11;
  assign addr        = is_cmd ? {addr_q, addr_q} : '0;
  assign dqs_burst   = in_data ? 2'b11 : (is_pre ? 2'b10 : 2'b00);
  assign wdata       = in_data ? data_cur : '0;
  assign dm          = in_data ? ~be_cur : '0;
  assign wdata_valid = !in_data ? 2'b00 : (save_mode ? slot_live : 2'b11);
endmodule

// File: rtl/hr_write_seq_chk.sv
module hr_write_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req,
  input logic       ready,
  input logic       save_mode,
  input logic [1:0] cs_n,
  input logic [1:0] dqs_burst,
  input logic [1:0] wdata_valid,
  input logic       dm_nz
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs_n == 2'b11 && dqs_burst == 2'b00 && wdata_valid == 2'b00 && !dm_nz));
  assert_cmd_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && ready) |=> (cs_n == 2'b01));
  assert_cmd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 2'b01) |=> (cs_n == 2'b11));
  assert_mask_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dm_nz |-> (dqs_burst == 2'b11));
  assert_full_mode_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_burst == 2'b11 && !save_mode) |-> (wdata_valid == 2'b11));
  assert_valid_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_valid != 2'b00) |-> (dqs_burst == 2'b11));
  assert_busy_on_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 2'b11) |-> !ready);
endmodule

bind hr_write_seq hr_write_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .ready(ready), .save_mode(save_mode),
  .cs_n(cs_n), .dqs_burst(dqs_burst), .wdata_valid(wdata_valid), .dm_nz(|dm)
);

// File: tb/sim_hr_write_seq.sv
module sim_hr_write_seq;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 13;
  localparam int DQ_W   = 16;
  localparam int LAT_W  = 4;
  localparam int BYTES  = DQ_W / 8;

  logic clk = 0, rst_n = 0, cal_done = 0, save_mode = 0, wr_req = 0;
  logic [LAT_W-1:0]    lat_in = '0;
  logic [ADDR_W-1:0]   wr_addr = '0;
  logic [8*DQ_W-1:0]   wr_data = '0;
  logic [8*BYTES-1:0]  wr_be = '0;
  logic                ready;
  logic [1:0]          cs_n, dqs_burst, wdata_valid;
  logic [2*ADDR_W-1:0] addr;
  logic [4*DQ_W-1:0]   wdata;
  logic [4*BYTES-1:0]  dm;

  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  hr_write_seq #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .lat_in(lat_in), .save_mode(save_mode),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .ready(ready),
    .cs_n(cs_n), .addr(addr), .dqs_burst(dqs_burst), .wdata_valid(wdata_valid),
    .wdata(wdata), .dm(dm));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready after reset", 128'(ready), 0);
    chk(cs_n == 2'b11, "R1 cs_n idle", 128'(cs_n), 3);
    chk(dqs_burst == 2'b00 && wdata_valid == 2'b00, "R1 dqs/valid idle",
        128'({dqs_burst, wdata_valid}), 0);
  endtask

  task automatic t_uncal();
    wr_req = 1; wr_addr = 13'h55;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cs_n == 2'b11, "R2 no command before calibration", 128'(cs_n), 3);
    end
    wr_req = 0;
  endtask

  task automatic t_cal(input logic [LAT_W-1:0] v);
    @(negedge clk); lat_in = v; cal_done = 1;
    @(negedge clk); cal_done = 0;
    chk(ready == 1'b1, "R9 ready after cal_done", 128'(ready), 1);
  endtask

  task automatic run_write(input logic [ADDR_W-1:0] a, input logic [8*DQ_W-1:0] d,
                           input logic [8*BYTES-1:0] be, input int L, input bit mode,
                           input bit poke, input string tag);
    logic [1:0] ecs, edqs, ev;
    logic [4*DQ_W-1:0] ed;
    logic [4*BYTES-1:0] edm, bec;
    @(negedge clk);
    save_mode = mode; wr_addr = a; wr_data = d; wr_be = be; wr_req = 1;
    chk(ready == 1'b1, {tag, " R8 ready before request"}, 128'(ready), 1);
    @(negedge clk);
    wr_req = 0;
    for (int p = 0; p <= L + 2; p++) begin
      ecs  = (p == 0) ? 2'b01 : 2'b11;
      edqs = (p == L || p == L + 1) ? 2'b11 : ((p == L - 1) ? 2'b10 : 2'b00);
      if (p == L || p == L + 1) begin
        ed  = d[(p - L) * 4 * DQ_W +: 4 * DQ_W];
        bec = be[(p - L) * 4 * BYTES +: 4 * BYTES];
        edm = ~bec;
        ev  = mode ? {|bec[2*BYTES +: 2*BYTES], |bec[0 +: 2*BYTES]} : 2'b11;
      end else begin
        ed = '0; edm = '0; ev = 2'b00;
      end
      chk(cs_n == ecs, {tag, " R3 cs_n"}, 128'(cs_n), 128'(ecs));
      if (p == 0) chk(addr == {a, a}, {tag, " R3 addr"}, 128'(addr), 128'({a, a}));
      chk(dqs_burst == edqs, {tag, " R4 dqs_burst"}, 128'(dqs_burst), 128'(edqs));
      chk(wdata == ed, {tag, " R5 wdata"}, 128'(wdata), 128'(ed));
      chk(dm == edm, {tag, " R5 dm"}, 128'(dm), 128'(edm));
      chk(wdata_valid == ev, {tag, mode ? " R7 valid" : " R6 valid"}, 128'(wdata_valid), 128'(ev));
      chk(ready == (p > L + 1), {tag, " R8 ready"}, 128'(ready), 128'(p > L + 1));
      if (poke && p == 1) begin wr_req = 1; wr_addr = ~a; end
      else wr_req = 0;
      if (p != L + 2) @(negedge clk);
    end
    wr_req = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [8*DQ_W-1:0] pat;
    pat = 128'h8877_6655_4433_2211_F0E1_D2C3_B4A5_9687;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_uncal();
    t_cal(4'd3);
    run_write(13'h1ABC, pat, 16'hFFFF, 3, 1'b0, 1'b0, "full");
    run_write(13'h0123, ~pat, 16'hFF0F, 3, 1'b0, 1'b0, "partial_r6");
    run_write(13'h0123, ~pat, 16'hFF0F, 3, 1'b1, 1'b0, "save_r7");
    run_write(13'h0777, pat, 16'h30F0, 3, 1'b1, 1'b0, "save_mixed_r7");
    run_write(13'h0042, pat, 16'hA5C3, 3, 1'b0, 1'b1, "busy_poke_r8");
    lat_in = 4'd7;
    run_write(13'h0F0F, pat, 16'hFFFF, 3, 1'b0, 1'b0, "lat_hold_r9");
    t_cal(4'd0);
    run_write(13'h1111, pat, 16'h0FFF, 1, 1'b0, 1'b0, "lat0_r4");
    t_cal(4'd6);
    run_write(13'h0002, ~pat, 16'hFFFF, 6, 1'b1, 1'b0, "lat6_r4");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule